// File: doc/BRIEF.md
# Sprite Pairwise Collision Detector

This block decides which pairs among a small set of fixed-size square sprites touch each other on screen. A host loads each sprite's top-left corner into a position table, then pulses `start`. The detector walks every unordered pair once. For each pair it first compares the two bounding squares. Only when the squares intersect does it fetch bitmap pixels, and it fetches only those that lie inside the intersection. A pair counts as colliding when both sprites show a non-transparent pixel at the same screen point.

Bitmap pixels come from an external synchronous memory through a read port. The port carries a sprite index, a row and a column, and returns data one cycle later. For each screen point the detector reads the lower-index sprite first and the higher-index sprite on the next cycle, then compares the two. It abandons a pair at the first shared opaque point. When every pair has been handled, a one-cycle `done` pulse marks the result vector as final. That vector holds one bit per pair and keeps its value until the next start.

The controller is a single state machine with these states. IDLE waits for `start`. RECT runs the square test for the current pair. RDA issues the read for the first sprite. RDB issues the read for the second sprite and captures the first pixel. CMP compares the two pixels. NEXT moves to the following pair. FIN raises `done`. Its transitions are:
- IDLE→RECT on start.
- RECT→RDA when the squares intersect, and RECT→NEXT when they do not.
- RDA→RDB, then RDB→CMP.
- CMP→NEXT on a hit or on the last point of the intersection; otherwise CMP→RDA.
- NEXT→RECT, or NEXT→FIN after the last pair.
- FIN→IDLE.

Top module: `sprite_collide`

## Requirements
- R1: After reset, `busy`, `done`, `bm_rd_en` and every bit of `hits` are 0.
- R2: A `start` pulse sampled while idle raises `busy` at the next edge and clears all of `hits` at that same edge.
- R3: Pairs (a,b) with a<b are visited in order of a, then b. The pair's result lands in bit k of `hits`, with k counting from 0 in that order: (0,1)=0, (0,2)=1, …, (0,7)=6, (1,2)=7, …, (6,7)=27.
- R4: Two sprites' squares intersect only when both |xa−xb| < 16 and |ya−yb| < 16. A pair whose squares do not intersect reads no pixels, never sets its bit, and costs exactly 2 cycles.
- R5: The pixel scan covers only the intersection, row by row, left to right. For each screen point (X,Y), a sprite is read at row Y−y and column X−x, using its own corner. Each point takes 3 cycles: one read for the lower index, one read for the higher index, and one compare.
- R6: A pixel equal to 16'h0000 is transparent and never produces a collision. Any other value is opaque.
- R7: A pair's scan stops at the first point where both pixels are opaque, and that pair's bit is set. A pair scanned through k points costs 1 + 3k + 1 cycles.
- R8: `done` is high for exactly one cycle, C edges after the start edge, where C is the sum of the pair costs. `busy` is high from the edge after start up to and including the `done` cycle.
- R9: `start` has no effect while `busy` is high.
- R10: `hits` holds its value while idle, until the next accepted start.
- R11: `pos_we` writes `pos_x` and `pos_y` into the table entry `pos_idx`, and the next scan uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full scan of all pairs |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when `hits` is final |
| pos_we | input | 1 | Position table write enable |
| pos_idx | input | 3 | Sprite index to write |
| pos_x | input | 11 | Top-left x coordinate |
| pos_y | input | 11 | Top-left y coordinate |
| bm_rd_en | output | 1 | Bitmap read request |
| bm_sprite | output | 3 | Sprite index of the read |
| bm_row | output | 4 | Row inside the sprite |
| bm_col | output | 4 | Column inside the sprite |
| bm_data | input | 16 | Pixel returned one cycle after the request |
| hits | output | 28 | One collision bit per pair |

## Verification
The bench goes after three edge cases:
- Square separations of exactly 15 and 16 on each axis. Using `<=` instead of `<` would flag the separation-16 pairs.
- Single-point collisions that only line up when each sprite's offset is taken from its own corner. A design that used one sprite's corner for both would miss them.
- A pair where one sprite is fully transparent across the intersection. A design that ignored transparency would report a false hit there.

A cycle model in the bench predicts the exact `done` edge and the total number of bitmap reads from the scan lengths. This exposes a missing early exit or a scan that runs past the intersection. A `start` pulse injected mid-scan checks that neither the result nor the timing changes.

// File: rtl/sprite_collide_pkg.sv
package sprite_collide_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECT,
        ST_RDA,
        ST_RDB,
        ST_CMP,
        ST_NEXT,
        ST_FIN
    } sc_state_t;
endpackage

// File: rtl/sprite_pos_table.sv
module sprite_pos_table #(
    parameter int N   = 8,
    parameter int CW  = 11,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [IDW-1:0] widx,
    input  logic [CW-1:0]  wx,
    input  logic [CW-1:0]  wy,
    input  logic [IDW-1:0] ra,
    input  logic [IDW-1:0] rb,
    output logic [CW-1:0]  xa,
    output logic [CW-1:0]  ya,
    output logic [CW-1:0]  xb,
    output logic [CW-1:0]  yb
);
    logic [CW-1:0] tx [N];
    logic [CW-1:0] ty [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx[g] <= '0;
                ty[g] <= '0;
            end else if (we && widx == IDW'(g)) begin
                tx[g] <= wx;
                ty[g] <= wy;
            end
        end
    end

    assign xa = tx[ra];
    assign ya = ty[ra];
    assign xb = tx[rb];
    assign yb = ty[rb];
endmodule

// File: rtl/sprite_rect_overlap.sv
module sprite_rect_overlap #(
    parameter int CW  = 11,
    parameter int DIM = 16,
    parameter int EW  = CW + 1
) (
    input  logic [CW-1:0] xa,
    input  logic [CW-1:0] ya,
    input  logic [CW-1:0] xb,
    input  logic [CW-1:0] yb,
    output logic          ovl,
    output logic [EW-1:0] ox,
    output logic [EW-1:0] oy,
    output logic [EW-1:0] ex,
    output logic [EW-1:0] ey
);
    logic [CW-1:0] dx, dy;
    logic [CW-1:0] xlo, xhi, ylo, yhi;

    always_comb begin
        xhi = (xa > xb) ? xa : xb;
        xlo = (xa > xb) ? xb : xa;
        yhi = (ya > yb) ? ya : yb;
        ylo = (ya > yb) ? yb : ya;
        dx  = xhi - xlo;
        dy  = yhi - ylo;
        ovl = (dx < CW'(DIM)) && (dy < CW'(DIM));
        ox  = EW'(xhi);
        oy  = EW'(yhi);
        ex  = EW'(xlo) + EW'(DIM - 1);
        ey  = EW'(ylo) + EW'(DIM - 1);
    end
endmodule

// File: rtl/sprite_scan_walker.sv
module sprite_scan_walker #(
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [EW-1:0] ox,
    input  logic [EW-1:0] oy,
    input  logic [EW-1:0] ex,
    input  logic [EW-1:0] ey,
    output logic [EW-1:0] px,
    output logic [EW-1:0] py,
    output logic          last
);
    logic [EW-1:0] ox_r, ex_r, ey_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px   <= '0;
            py   <= '0;
            ox_r <= '0;
            ex_r <= '0;
            ey_r <= '0;
        end else if (load) begin
            px   <= ox;
            py   <= oy;
            ox_r <= ox;
            ex_r <= ex;
            ey_r <= ey;
        end else if (step) begin
            if (px == ex_r) begin
                px <= ox_r;
                py <= py + EW'(1);
            end else begin
                px <= px + EW'(1);
            end
        end
    end

    assign last = (px == ex_r) && (py == ey_r);
endmodule

// File: rtl/sprite_collide.sv
module sprite_collide
    import sprite_collide_pkg::*;
#(
    parameter int N    = 8,
    parameter int CW   = 11,
    parameter int DIM  = 16,
    parameter int PIXW = 16,
    parameter int IDW  = $clog2(N),
    parameter int OFW  = $clog2(DIM),
    parameter int NPR  = N * (N - 1) / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            done,
    input  logic            pos_we,
    input  logic [IDW-1:0]  pos_idx,
    input  logic [CW-1:0]   pos_x,
    input  logic [CW-1:0]   pos_y,
    output logic            bm_rd_en,
    output logic [IDW-1:0]  bm_sprite,
    output logic [OFW-1:0]  bm_row,
    output logic [OFW-1:0]  bm_col,
    input  logic [PIXW-1:0] bm_data,
    output logic [NPR-1:0]  hits
);
    localparam int EW  = CW + 1;
    localparam int PKW = $clog2(NPR);

    sc_state_t      state, nstate;
    logic [IDW-1:0] ia, ib;
    logic [PKW-1:0] pk;
    logic [PIXW-1:0] pix_a;
    logic [CW-1:0]  xa, ya, xb, yb;
    logic           ovl, last_pt, last_pair, both_opq;
    logic [EW-1:0]  ox, oy, ex, ey, px, py;
    logic           w_load, w_step;

    sprite_pos_table #(.N(N), .CW(CW), .IDW(IDW)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(pos_we), .widx(pos_idx),
        .wx(pos_x), .wy(pos_y), .ra(ia), .rb(ib),
        .xa(xa), .ya(ya), .xb(xb), .yb(yb)
    );

    sprite_rect_overlap #(.CW(CW), .DIM(DIM), .EW(EW)) u_ovl (
        .xa(xa), .ya(ya), .xb(xb), .yb(yb),
        .ovl(ovl), .ox(ox), .oy(oy), .ex(ex), .ey(ey)
    );

    sprite_scan_walker #(.EW(EW)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(w_load), .step(w_step),
        .ox(ox), .oy(oy), .ex(ex), .ey(ey),
        .px(px), .py(py), .last(last_pt)
    );

    assign last_pair = (ia == IDW'(N - 2)) && (ib == IDW'(N - 1));
    assign both_opq  = (pix_a != '0) && (bm_data != '0);
    assign w_load    = (state == ST_RECT) && ovl;
    assign w_step    = (state == ST_CMP) && !both_opq && !last_pt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_RECT;
            ST_RECT: nstate = ovl ? ST_RDA : ST_NEXT;
            ST_RDA:  nstate = ST_RDB;
            ST_RDB:  nstate = ST_CMP;
            ST_CMP:  nstate = (both_opq || last_pt) ? ST_NEXT : ST_RDA;
            ST_NEXT: nstate = last_pair ? ST_FIN : ST_RECT;
            ST_FIN:  nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // pair pointers, pixel capture and result bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ia    <= '0;
            ib    <= IDW'(1);
            pk    <= '0;
            pix_a <= '0;
            hits  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ia   <= '0;
                    ib   <= IDW'(1);
                    pk   <= '0;
                    hits <= '0;
                end
                ST_RDB: pix_a <= bm_data;
                ST_CMP: if (both_opq) hits[pk] <= 1'b1;
                ST_NEXT: if (!last_pair) begin
                    pk <= pk + PKW'(1);
                    if (ib == IDW'(N - 1)) begin
                        ia <= ia + IDW'(1);
                        ib <= ia + IDW'(2);
                    end else begin
                        ib <= ib + IDW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        bm_rd_en  = 1'b0;
        bm_sprite = ia;
        bm_row    = OFW'(py - EW'(ya));
        bm_col    = OFW'(px - EW'(xa));
        unique case (state)
            ST_RDA: bm_rd_en = 1'b1;
            ST_RDB: begin
                bm_rd_en  = 1'b1;
                bm_sprite = ib;
                bm_row    = OFW'(py - EW'(yb));
                bm_col    = OFW'(px - EW'(xb));
            end
            default: ;
        endcase
    end

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done only ends a running scan
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R4: no bitmap traffic outside a scan
    a_r4_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bm_rd_en |-> busy);
    // R7: bits only get set during a scan
    a_r7_bits_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((hits & $past(hits)) == $past(hits)));
    // R10: result held while idle
    a_r10_hits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(hits));
    // R9: start cannot cut a scan short
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_sprite_collide.sv
module sim_sprite_collide;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done;
    logic        pos_we = 1'b0;
    logic [2:0]  pos_idx = '0;
    logic [10:0] pos_x = '0, pos_y = '0;
    logic        bm_rd_en;
    logic [2:0]  bm_sprite;
    logic [3:0]  bm_row, bm_col;
    logic [15:0] bm_data = '0;
    logic [27:0] hits;

    int n_chk = 0;
    int n_bad = 0;
    int xs [8];
    int ys [8];
    logic [255:0] opq [8];

    always #2 clk = ~clk;

    sprite_collide u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pos_we(pos_we), .pos_idx(pos_idx), .pos_x(pos_x), .pos_y(pos_y),
        .bm_rd_en(bm_rd_en), .bm_sprite(bm_sprite), .bm_row(bm_row),
        .bm_col(bm_col), .bm_data(bm_data), .hits(hits)
    );

    function automatic logic [15:0] pix(input int s, input int r, input int c);
        if (opq[s][r*16+c]) return 16'h8000 | 16'(s*256 + r*16 + c);
        return 16'h0000;
    endfunction

    // bitmap memory, one-cycle read latency
    always @(posedge clk)
        bm_data <= bm_rd_en ? pix(int'(bm_sprite), int'(bm_row), int'(bm_col)) : 16'h0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input int i, input int x, input int y);
        @(negedge clk);
        pos_we = 1'b1; pos_idx = 3'(i); pos_x = 11'(x); pos_y = 11'(y);
        xs[i] = x; ys[i] = y;
        @(negedge clk);
        pos_we = 1'b0;
    endtask

    // behavioural model: expected hits, cycle total, read total
    task automatic model(output logic [27:0] eh, output int ec, output int er);
        int k;
        eh = '0; ec = 0; er = 0; k = 0;
        for (int a = 0; a < 8; a++)
            for (int b = a + 1; b < 8; b++) begin
                int dx, dy, pts;
                bit hit;
                dx = xs[a] - xs[b]; if (dx < 0) dx = -dx;
                dy = ys[a] - ys[b]; if (dy < 0) dy = -dy;
                pts = 0; hit = 0;
                if (dx < 16 && dy < 16) begin
                    int x0, y0, x1, y1;
                    x0 = (xs[a] > xs[b]) ? xs[a] : xs[b];
                    y0 = (ys[a] > ys[b]) ? ys[a] : ys[b];
                    x1 = ((xs[a] < xs[b]) ? xs[a] : xs[b]) + 15;
                    y1 = ((ys[a] < ys[b]) ? ys[a] : ys[b]) + 15;
                    for (int yy = y0; yy <= y1 && !hit; yy++)
                        for (int xx = x0; xx <= x1 && !hit; xx++) begin
                            pts++;
                            if (opq[a][(yy-ys[a])*16 + (xx-xs[a])] &&
                                opq[b][(yy-ys[b])*16 + (xx-xs[b])]) hit = 1;
                        end
                    ec += 2 + 3 * pts;
                    er += 2 * pts;
                end else begin
                    ec += 2;
                end
                eh[k] = hit;
                k++;
            end
    endtask

    // one scan, compared against the model on every clock
    task automatic run_scan(input int mid_start, input string tag);
        logic [27:0] eh;
        int ec, er, reads;
        model(eh, ec, er);
        reads = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n <= ec + 1; n++) begin
            if (n == mid_start) start = 1'b1;
            if (n == mid_start + 1) start = 1'b0;
            chk(done == (n == ec), {"R8 done timing ", tag}, done, n == ec);
            chk(busy == (n <= ec), {"R8 busy window ", tag}, busy, n <= ec);
            chk((hits & ~eh) == '0, {"R2 R4 R6 no spurious bit ", tag}, hits, eh);
            if (bm_rd_en) reads++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(hits == eh, {"R3 R5 R6 R7 result ", tag}, hits, eh);
        chk(reads == er, {"R5 R7 read count ", tag}, reads, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        for (int s = 0; s < 8; s++) begin
            opq[s] = '1; xs[s] = 0; ys[s] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && bm_rd_en == 0 && hits == '0, "R1 reset",
            {busy, done, bm_rd_en}, 0);
        rst_n = 1'b1;

        // R4 R11: all apart, no reads, 2 cycles per pair
        for (int s = 0; s < 8; s++) wr(s, s * 100, 7);
        run_scan(-5, "apart");
        chk(hits == '0, "R4 apart hits", hits, 0);

        // R3 R4: boundaries 15 vs 16, bit mapping
        wr(0, 10, 10);   wr(1, 12, 13);
        wr(2, 300, 50);  wr(3, 315, 50);
        wr(4, 500, 500); wr(5, 516, 500);
        wr(6, 700, 10);  wr(7, 700, 26);
        run_scan(-5, "bound");
        chk(hits == 28'h0002001, "R3 bits 0 and 13 only", hits, 28'h0002001);

        // R10: hold while idle
        repeat (6) @(negedge clk);
        chk(hits == 28'h0002001, "R10 hold", hits, 28'h0002001);

        // R6: sprite 1 fully transparent
        opq[1] = '0;
        run_scan(-5, "transp");
        chk(hits[0] == 1'b0, "R6 transparent pair", hits[0], 0);

        // R5: single point aligned only with own-corner offsets
        opq[0] = '0; opq[0][5*16+7] = 1'b1;
        opq[1] = '0; opq[1][2*16+5] = 1'b1; opq[1][5*16+7] = 1'b1;
        // R7: early exit deep in column
        opq[2] = '0; opq[2][9*16+15] = 1'b1;
        run_scan(-5, "offset");
        chk(hits[0] == 1'b1, "R5 offset hit", hits[0], 1);
        chk(hits[13] == 1'b1, "R7 early exit hit", hits[13], 1);

        // R9: start pulse mid-scan has no effect
        run_scan(20, "midstart");

        // R11 R2: move sprites apart, fresh scan clears bits
        wr(1, 900, 900); wr(3, 1200, 50);
        run_scan(-5, "moved");
        chk(hits == '0, "R11 R2 moved sprites", hits, 0);

        summary();
    end
endmodule